// File: doc/BRIEF.md
# Reset Arbitration and Clock-Enable Sequencer

This block sits between the reset request sources of a chip and its clock tree. It accepts three requests: an external reset pin and two watchdog-originated requests. It turns them into a small set of enables: the main oscillator, the CPU, system and peripheral clocks, and the watchdog clock. It also drives a port high-impedance control, a one-cycle pulse that re-initialises peripheral registers, and a code naming the source of the most recent reset.

Requests fall into two classes. A heavy reset (the pin, or the heavy watchdog request) stops the oscillator and the watchdog clock while it is active. After release it holds the core clocks off for a programmable stabilization interval while the oscillator restarts. A light reset (the light watchdog request) keeps the oscillator and watchdog clock running and gives the core clocks back on the cycle after it ends. Heavy beats light when both are present, and a heavy request upgrades a light reset already in progress. A subclock enable passes straight through and is not touched by any reset.

Top module: `reset_clock_sequencer`

## Requirements
- R1: The pin request is set asynchronously and released through a two-flop synchroniser. Heavy-reset outputs appear from the first rising clock edge after the pin rises. After the pin falls they persist through two further rising edges and change on the third.
- R2: While a heavy reset is active, osc_en_o, wdt_clk_en_o, cpu_clk_en_o, sys_clk_en_o and per_clk_en_o are 0 and port_hiz_o is 1. Outputs follow a watchdog request one rising edge after it is sampled.
- R3: On release of a heavy reset with sampled interval N, the next N cycles show osc_en_o=1, wdt_clk_en_o=1, port_hiz_o=0 and all three core clock enables 0, after which the core clocks turn on. With N=0 the core clocks turn on directly.
- R4: stab_cnt_i is sampled only in the cycle the heavy reset is released. Later changes to it do not alter the running interval.
- R5: While a light reset is active, osc_en_o=1, wdt_clk_en_o=1, port_hiz_o=1 and all core clock enables are 0. The core clocks return on the rising edge that samples the request low, with no stabilization wait.
- R6: Simultaneous heavy and light requests give a heavy reset. A heavy request during a light reset switches to the heavy path. A heavy request during stabilization restarts the heavy reset.
- R7: A light request during the stabilization interval is ignored. The outputs keep the stabilization pattern, the cause code is unchanged, no init pulse is issued, and the interval ends on its original cycle.
- R8: periph_init_o is a one-cycle pulse in the first cycle of every entry into a reset state caused by a request, including the upgrade from light to heavy.
- R9: cause_o is updated on each entry into a reset state with the priority pin over heavy watchdog over light watchdog. Its encoding is 0 = power-on (rst_i), 1 = pin, 2 = heavy watchdog, 3 = light watchdog. It holds its value between entries.
- R10: sub_clk_en_o always equals sub_clk_req_i, whatever the reset state.
- R11: rst_i (synchronous, active high) puts the block in the heavy-reset pattern with cause 0 and no init pulse. After it is released, the block runs a stabilization interval taken from stab_cnt_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high power-on reset |
| pin_rst_i | input | 1 | External reset pin request, asynchronous, active high |
| wdt_heavy_i | input | 1 | Heavy watchdog reset request, synchronous level |
| wdt_light_i | input | 1 | Light watchdog reset request, synchronous level |
| stab_cnt_i | input | 16 | Stabilization interval in cycles, sampled at heavy release |
| sub_clk_req_i | input | 1 | Requested subclock enable |
| osc_en_o | output | 1 | Main oscillator enable |
| cpu_clk_en_o | output | 1 | CPU clock enable |
| sys_clk_en_o | output | 1 | System clock enable |
| per_clk_en_o | output | 1 | Peripheral clock enable |
| wdt_clk_en_o | output | 1 | Watchdog clock enable |
| sub_clk_en_o | output | 1 | Subclock enable |
| port_hiz_o | output | 1 | Port high-impedance control |
| periph_init_o | output | 1 | Peripheral register initialisation pulse |
| cause_o | output | 2 | Source of the last reset |

## Verification
Two functions can meet in one cycle. The first is arbitration between the two reset classes: the bench applies every non-empty combination of the three requests in one cycle, raises a heavy request while a light reset is running, and raises a pin request during stabilization. The pattern, cause code and init pulse that follow are compared with the heavy-wins rule. The second is the stabilization countdown meeting a new request: a light request placed inside the interval must leave the countdown length unchanged, and the bench counts the cycles until the core clocks return.

// File: rtl/rcs_pkg.sv
package rcs_pkg;

    localparam int STAB_W = 16;

    typedef enum logic [1:0] {
        SEQ_RUN   = 2'd0,
        SEQ_LIGHT = 2'd1,
        SEQ_HEAVY = 2'd2,
        SEQ_STAB  = 2'd3
    } seq_state_e;

    typedef enum logic [1:0] {
        CAUSE_POWER     = 2'd0,
        CAUSE_PIN       = 2'd1,
        CAUSE_WDT_HEAVY = 2'd2,
        CAUSE_WDT_LIGHT = 2'd3
    } rst_cause_e;

    typedef struct packed {
        logic osc;
        logic cpu;
        logic sys;
        logic per;
        logic wdt;
        logic hiz;
    } clk_ctl_t;

    function automatic logic is_reset_state(seq_state_e s);
        return (s == SEQ_LIGHT) || (s == SEQ_HEAVY);
    endfunction

    function automatic rst_cause_e pick_cause(logic pin_req, logic wdt_heavy_req);
        if (pin_req) begin
            return CAUSE_PIN;
        end
        if (wdt_heavy_req) begin
            return CAUSE_WDT_HEAVY;
        end
        return CAUSE_WDT_LIGHT;
    endfunction

    function automatic clk_ctl_t decode_ctl(seq_state_e s);
        clk_ctl_t c;
        c = '{osc: 1'b1, cpu: 1'b0, sys: 1'b0, per: 1'b0, wdt: 1'b1, hiz: 1'b0};
        case (s)
            SEQ_RUN: begin
                c.cpu = 1'b1;
                c.sys = 1'b1;
                c.per = 1'b1;
            end
            SEQ_LIGHT: begin
                c.hiz = 1'b1;
            end
            SEQ_HEAVY: begin
                c.osc = 1'b0;
                c.wdt = 1'b0;
                c.hiz = 1'b1;
            end
            default: begin
            end
        endcase
        return c;
    endfunction

endpackage

// File: rtl/rcs_pin_sync.sv
module rcs_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic pin_i,
    output logic req_o
);
    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk_i or posedge pin_i) begin
                if (pin_i) begin
                    chain_q <= 1'b1;
                end else begin
                    chain_q <= 1'b0;
                end
            end
        end else begin : g_multi
            always_ff @(posedge clk_i or posedge pin_i) begin
                if (pin_i) begin
                    chain_q <= '1;
                end else if (rst_i) begin
                    chain_q <= '0;
                end else begin
                    chain_q <= {chain_q[STAGES-2:0], 1'b0};
                end
            end
        end
    endgenerate

    assign req_o = chain_q[STAGES-1];
endmodule

// File: rtl/rcs_stab_timer.sv
module rcs_stab_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic             last_o
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= load_val_i;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - ONE;
        end
    end

    assign last_o = (cnt_q == ONE);
endmodule

// File: rtl/rcs_seq_fsm.sv
module rcs_seq_fsm
    import rcs_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_i,
    input  logic       pin_req_i,
    input  logic       wdt_heavy_i,
    input  logic       wdt_light_i,
    input  logic       stab_zero_i,
    input  logic       stab_last_i,
    output seq_state_e state_o,
    output rst_cause_e cause_o,
    output logic       init_pulse_o,
    output logic       stab_load_o
);
    seq_state_e state_q;
    seq_state_e state_d;
    rst_cause_e cause_q;
    logic       init_q;
    logic       heavy_req;
    logic       entering;

    assign heavy_req = pin_req_i | wdt_heavy_i;

    always_comb begin
        state_d = state_q;
        case (state_q)
            SEQ_RUN: begin
                if (heavy_req) begin
                    state_d = SEQ_HEAVY;
                end else if (wdt_light_i) begin
                    state_d = SEQ_LIGHT;
                end
            end
            SEQ_LIGHT: begin
                if (heavy_req) begin
                    state_d = SEQ_HEAVY;
                end else if (!wdt_light_i) begin
                    state_d = SEQ_RUN;
                end
            end
            SEQ_HEAVY: begin
                if (!heavy_req) begin
                    state_d = stab_zero_i ? SEQ_RUN : SEQ_STAB;
                end
            end
            default: begin
                if (heavy_req) begin
                    state_d = SEQ_HEAVY;
                end else if (stab_last_i) begin
                    state_d = SEQ_RUN;
                end
            end
        endcase
    end

    assign entering = is_reset_state(state_d) && (state_d != state_q);

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            state_q <= SEQ_HEAVY;
            cause_q <= CAUSE_POWER;
            init_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            init_q  <= entering;
            if (entering) begin
                cause_q <= pick_cause(pin_req_i, wdt_heavy_i);
            end
        end
    end

    assign state_o      = state_q;
    assign cause_o      = cause_q;
    assign init_pulse_o = init_q;
    assign stab_load_o  = (state_q == SEQ_HEAVY) && !heavy_req;
endmodule

// File: rtl/reset_clock_sequencer.sv
module reset_clock_sequencer
    import rcs_pkg::*;
#(
    parameter int CNT_W       = rcs_pkg::STAB_W,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             pin_rst_i,
    input  logic             wdt_heavy_i,
    input  logic             wdt_light_i,
    input  logic [CNT_W-1:0] stab_cnt_i,
    input  logic             sub_clk_req_i,
    output logic             osc_en_o,
    output logic             cpu_clk_en_o,
    output logic             sys_clk_en_o,
    output logic             per_clk_en_o,
    output logic             wdt_clk_en_o,
    output logic             sub_clk_en_o,
    output logic             port_hiz_o,
    output logic             periph_init_o,
    output logic [1:0]       cause_o
);
    logic       pin_sync;
    logic       stab_last;
    logic       stab_load;
    seq_state_e state;
    rst_cause_e cause;
    clk_ctl_t   ctl;

    rcs_pin_sync #(.STAGES(SYNC_STAGES)) u_pin_sync (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .pin_i (pin_rst_i),
        .req_o (pin_sync)
    );

    rcs_stab_timer #(.CNT_W(CNT_W)) u_stab_timer (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .load_i     (stab_load),
        .load_val_i (stab_cnt_i),
        .last_o     (stab_last)
    );

    rcs_seq_fsm u_seq_fsm (
        .clk_i        (clk_i),
        .rst_i        (rst_i),
        .pin_req_i    (pin_sync),
        .wdt_heavy_i  (wdt_heavy_i),
        .wdt_light_i  (wdt_light_i),
        .stab_zero_i  (stab_cnt_i == '0),
        .stab_last_i  (stab_last),
        .state_o      (state),
        .cause_o      (cause),
        .init_pulse_o (periph_init_o),
        .stab_load_o  (stab_load)
    );

    assign ctl          = decode_ctl(state);
    assign osc_en_o     = ctl.osc;
    assign cpu_clk_en_o = ctl.cpu;
    assign sys_clk_en_o = ctl.sys;
    assign per_clk_en_o = ctl.per;
    assign wdt_clk_en_o = ctl.wdt;
    assign port_hiz_o   = ctl.hiz;
    assign cause_o      = cause;
    assign sub_clk_en_o = sub_clk_req_i;
endmodule

// File: rtl/rcs_checker.sv
module rcs_checker (
    input logic       clk_i,
    input logic       rst_i,
    input logic       pin_sync,
    input logic       wdt_heavy_i,
    input logic       wdt_light_i,
    input logic       osc_en_o,
    input logic       cpu_clk_en_o,
    input logic       wdt_clk_en_o,
    input logic       port_hiz_o,
    input logic       periph_init_o,
    input logic [1:0] cause_o
);
    AST_HEAVY_STOPS_ALL: assert property (@(posedge clk_i) disable iff (rst_i)
        (pin_sync || wdt_heavy_i) |=> (!osc_en_o && !wdt_clk_en_o && !cpu_clk_en_o && port_hiz_o)); // R2

    AST_LIGHT_KEEPS_OSC: assert property (@(posedge clk_i) disable iff (rst_i)
        (wdt_light_i && !pin_sync && !wdt_heavy_i) |=> (osc_en_o && wdt_clk_en_o)); // R5

    AST_LIGHT_FROM_RUN: assert property (@(posedge clk_i) disable iff (rst_i)
        (wdt_light_i && !pin_sync && !wdt_heavy_i && cpu_clk_en_o) |=> (port_hiz_o && !cpu_clk_en_o)); // R5

    AST_INIT_ON_ENTRY: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(port_hiz_o) |-> periph_init_o); // R8

    AST_CAUSE_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
        !periph_init_o |-> $stable(cause_o)); // R9
endmodule

bind reset_clock_sequencer rcs_checker chk_i (
    .clk_i         (clk_i),
    .rst_i         (rst_i),
    .pin_sync      (pin_sync),
    .wdt_heavy_i   (wdt_heavy_i),
    .wdt_light_i   (wdt_light_i),
    .osc_en_o      (osc_en_o),
    .cpu_clk_en_o  (cpu_clk_en_o),
    .wdt_clk_en_o  (wdt_clk_en_o),
    .port_hiz_o    (port_hiz_o),
    .periph_init_o (periph_init_o),
    .cause_o       (cause_o)
);

// File: tb/reset_clock_sequencer_tb.sv
module reset_clock_sequencer_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG_CYCLES = 20000;

    // pattern bits {osc, cpu, sys, per, wdt, hiz}
    localparam logic [5:0] P_RUN   = 6'b111110;
    localparam logic [5:0] P_LIGHT = 6'b100011;
    localparam logic [5:0] P_HEAVY = 6'b000001;
    localparam logic [5:0] P_STAB  = 6'b100010;

    logic        clk = 1'b0;
    logic        rst_i;
    logic        pin_rst_i;
    logic        wdt_heavy_i;
    logic        wdt_light_i;
    logic [15:0] stab_cnt_i;
    logic        sub_clk_req_i;
    logic        osc_en_o, cpu_clk_en_o, sys_clk_en_o, per_clk_en_o;
    logic        wdt_clk_en_o, sub_clk_en_o, port_hiz_o, periph_init_o;
    logic [1:0]  cause_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    reset_clock_sequencer dut_i (
        .clk_i         (clk),
        .rst_i         (rst_i),
        .pin_rst_i     (pin_rst_i),
        .wdt_heavy_i   (wdt_heavy_i),
        .wdt_light_i   (wdt_light_i),
        .stab_cnt_i    (stab_cnt_i),
        .sub_clk_req_i (sub_clk_req_i),
        .osc_en_o      (osc_en_o),
        .cpu_clk_en_o  (cpu_clk_en_o),
        .sys_clk_en_o  (sys_clk_en_o),
        .per_clk_en_o  (per_clk_en_o),
        .wdt_clk_en_o  (wdt_clk_en_o),
        .sub_clk_en_o  (sub_clk_en_o),
        .port_hiz_o    (port_hiz_o),
        .periph_init_o (periph_init_o),
        .cause_o       (cause_o)
    );

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic chk_pat(input string req, input logic [5:0] exp);
        chk(req, {2'b00, osc_en_o, cpu_clk_en_o, sys_clk_en_o, per_clk_en_o, wdt_clk_en_o, port_hiz_o},
            {2'b00, exp});
    endtask

    task automatic chk_init(input string req, input logic exp);
        chk(req, {7'd0, periph_init_o}, {7'd0, exp});
    endtask

    task automatic chk_cause(input string req, input logic [1:0] exp);
        chk(req, {6'd0, cause_o}, {6'd0, exp});
    endtask

    // heavy reset from RUN, via pin or heavy watchdog, interval n
    task automatic heavy_run(input bit use_pin, input int n);
        logic [1:0] exp_cause;
        exp_cause = use_pin ? 2'd1 : 2'd2;
        stab_cnt_i = 16'(n);
        if (use_pin) pin_rst_i = 1'b1; else wdt_heavy_i = 1'b1;
        tick();
        chk_pat("R2 heavy pattern", P_HEAVY);
        chk_init("R8 init pulse on heavy entry", 1'b1);
        chk_cause("R9 heavy cause", exp_cause);
        sub_clk_req_i = ~sub_clk_req_i;
        #1;
        chk("R10 subclock pass-through in heavy", {7'd0, sub_clk_en_o}, {7'd0, sub_clk_req_i});
        tick();
        chk_pat("R2 heavy pattern held", P_HEAVY);
        chk_init("R8 init pulse one cycle", 1'b0);
        if (use_pin) begin
            pin_rst_i = 1'b0;
            tick();
            chk_pat("R1 pin release edge 1", P_HEAVY);
            tick();
            chk_pat("R1 pin release edge 2", P_HEAVY);
            tick();
        end else begin
            wdt_heavy_i = 1'b0;
            tick();
        end
        for (int i = 0; i < n; i++) begin
            chk_pat("R3 stabilization pattern", P_STAB);
            if (i == 0) stab_cnt_i = 16'(n + 3);
            tick();
        end
        chk_pat("R3 R4 core clocks after interval", P_RUN);
        chk_cause("R9 cause retained", exp_cause);
    endtask

    task automatic light_run(input int len);
        wdt_light_i = 1'b1;
        for (int i = 0; i < len; i++) begin
            tick();
            chk_pat("R5 light pattern", P_LIGHT);
            chk_init("R8 init on light entry only", (i == 0) ? 1'b1 : 1'b0);
            chk_cause("R9 light cause", 2'd3);
        end
        wdt_light_i = 1'b0;
        tick();
        chk_pat("R5 light release no wait", P_RUN);
    endtask

    initial begin
        repeat (WATCHDOG_CYCLES) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_i = 1'b1;
        pin_rst_i = 1'b0;
        wdt_heavy_i = 1'b0;
        wdt_light_i = 1'b0;
        stab_cnt_i = 16'd2;
        sub_clk_req_i = 1'b0;

        // R11: power-on reset
        tick();
        chk_pat("R11 reset pattern", P_HEAVY);
        chk_cause("R11 reset cause", 2'd0);
        chk_init("R11 no init pulse in reset", 1'b0);
        tick();
        rst_i = 1'b0;
        tick();
        chk_pat("R11 stabilization after reset 1", P_STAB);
        tick();
        chk_pat("R11 stabilization after reset 2", P_STAB);
        tick();
        chk_pat("R11 run after reset", P_RUN);

        // R10: subclock in run
        sub_clk_req_i = 1'b1;
        #1;
        chk("R10 subclock pass-through in run", {7'd0, sub_clk_en_o}, 8'd1);
        tick();

        // R1 R2 R3 R4: sweep intervals and heavy sources
        for (int n = 0; n <= 5; n++) begin
            heavy_run(1'b1, n);
            heavy_run(1'b0, n);
        end

        // R5: light lengths
        for (int len = 1; len <= 4; len++) begin
            light_run(len);
        end

        // R6 R9: all simultaneous request combinations
        for (int c = 1; c < 8; c++) begin
            stab_cnt_i = 16'd0;
            pin_rst_i = c[2];
            wdt_heavy_i = c[1];
            wdt_light_i = c[0];
            tick();
            chk_pat("R6 priority pattern", (c[2] | c[1]) ? P_HEAVY : P_LIGHT);
            chk_cause("R9 priority cause", c[2] ? 2'd1 : (c[1] ? 2'd2 : 2'd3));
            chk_init("R8 init on combined entry", 1'b1);
            pin_rst_i = 1'b0;
            wdt_heavy_i = 1'b0;
            wdt_light_i = 1'b0;
            repeat (4) tick();
            chk_pat("R6 back to run", P_RUN);
        end

        // R6: upgrade from light to heavy
        wdt_light_i = 1'b1;
        tick();
        chk_pat("R6 light before upgrade", P_LIGHT);
        tick();
        chk_init("R8 no pulse inside light", 1'b0);
        wdt_heavy_i = 1'b1;
        tick();
        chk_pat("R6 upgraded to heavy", P_HEAVY);
        chk_init("R8 pulse on upgrade", 1'b1);
        chk_cause("R9 upgrade cause", 2'd2);
        wdt_heavy_i = 1'b0;
        wdt_light_i = 1'b0;
        stab_cnt_i = 16'd0;
        tick();
        chk_pat("R6 run after upgrade", P_RUN);

        // R7: light request during stabilization is ignored
        stab_cnt_i = 16'd4;
        wdt_heavy_i = 1'b1;
        tick();
        wdt_heavy_i = 1'b0;
        tick();
        chk_pat("R7 stab cycle 1", P_STAB);
        wdt_light_i = 1'b1;
        tick();
        chk_pat("R7 stab cycle 2 with light", P_STAB);
        chk_init("R7 no pulse for ignored light", 1'b0);
        chk_cause("R7 cause unchanged", 2'd2);
        wdt_light_i = 1'b0;
        tick();
        chk_pat("R7 stab cycle 3", P_STAB);
        tick();
        chk_pat("R7 stab cycle 4", P_STAB);
        tick();
        chk_pat("R7 interval ends on time", P_RUN);

        // R6: pin during stabilization restarts heavy
        stab_cnt_i = 16'd3;
        wdt_heavy_i = 1'b1;
        tick();
        wdt_heavy_i = 1'b0;
        tick();
        chk_pat("R6 stab before pin", P_STAB);
        pin_rst_i = 1'b1;
        tick();
        chk_pat("R6 heavy restart from stab", P_HEAVY);
        chk_init("R8 pulse on restart", 1'b1);
        chk_cause("R9 pin cause on restart", 2'd1);
        pin_rst_i = 1'b0;
        stab_cnt_i = 16'd0;
        tick();
        tick();
        tick();
        chk_pat("R1 run after restart release", P_RUN);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule